// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This unit watches a processor's activity for debug events. Each clock cycle it may see an instruction fetch address, a memory data access (address, size code, read or write) and a port I/O access (port number, size code). It compares all of these against four programmable address slots. Each slot is configured through one shared control word that holds its enables, its match kind and its length. When an enabled slot matches, or when a single-step trap is requested, the unit records the per-slot hit vector in its status register and pulses a debug-trap output for one cycle.

Software reaches the slot addresses, the status register and the control register through a small indexed register port. A debug-extensions mode input decides whether two legacy indices alias the status and control registers or are rejected. Indices outside the register map produce an illegal-access pulse. Every input is sampled on each rising edge, and the unit never stalls, so the edge has no valid/ready pairs and applies no back-pressure. Each strobe stands for exactly one event in the cycle in which it is high.

Top module: `dbg_trap_unit`

## Requirements
- R1: Slot i is enabled when control bit 2i or bit 2i+1 is set. Its 2-bit kind field sits at control bits 16+4i and its 2-bit length field at bits 18+4i. Kind codes are 0 execute, 1 data-write-only, 2 port I/O, 3 data read-or-write.
- R2: The length code maps 0 to 1 byte, 1 to 2 bytes, 2 to 8 bytes and 3 to 4 bytes.
- R3: An execute slot hits only when `fetch_vld_i` is high and `fetch_addr_i` equals the slot address exactly.
- R4: A data slot first aligns its address down to a multiple of its length. It hits when the access range [addr, addr+2^size-1] overlaps the slot range. This is computed without wrap at the top of the address space. A write-only slot ignores reads, and a read-or-write slot matches both.
- R5: A port I/O slot hits when [port, port+2^size-1] overlaps [slot, slot+length-1]. The slot address is not aligned for this test.
- R6: If a cycle has at least one hit on an enabled slot, `dbg_trap_o` is high in the next cycle. On the same edge, status bits 3:0 take the hit vector of all slots, including disabled ones. With no enabled hit and no step request, no trap is raised and the status is left unchanged.
- R7: `step_i` always raises the trap, sets status bit 14 and replaces status bits 3:0 with the hit vector. Bit 14 stays set through later traps until software writes it.
- R8: Register indices 0 to 3 select the slot addresses, 6 the status and 7 the control register. A legal read returns its data on `reg_rdata_o` with `reg_rvld_o` high one cycle later.
- R9: Reset leaves the slots at zero, the status at 32'hFFFF0FF0 and the control at 32'h00000400. Writes to status OR in 32'hFFFF0FF0, and writes to control OR in 32'h00000400.
- R10: An index of 8 to 15 pulses `reg_illegal_o` one cycle later. No read data is returned and a write changes nothing.
- R11: With `dext_en_i` low, index 4 aliases status and index 5 aliases control. With it high, those indices are illegal as in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| dext_en_i | input | 1 | Debug-extensions mode, disables the index 4/5 alias |
| fetch_vld_i | input | 1 | Instruction fetch present this cycle |
| fetch_addr_i | input | ADDR_W | Instruction address |
| mem_vld_i | input | 1 | Data access present this cycle |
| mem_wr_i | input | 1 | Data access is a write |
| mem_addr_i | input | ADDR_W | Data access start address |
| mem_size_i | input | 2 | Data access size, log2 bytes |
| io_vld_i | input | 1 | Port I/O access present this cycle |
| io_port_i | input | PORT_W | Port number |
| io_size_i | input | 2 | Port access size, log2 bytes |
| step_i | input | 1 | Single-step trap request |
| reg_vld_i | input | 1 | Register access strobe |
| reg_wr_i | input | 1 | Register access is a write |
| reg_idx_i | input | 4 | Register index |
| reg_wdata_i | input | ADDR_W | Register write data |
| reg_rdata_o | output | ADDR_W | Register read data |
| reg_rvld_o | output | 1 | Read data valid |
| reg_illegal_o | output | 1 | Illegal register index pulse |
| dbg_trap_o | output | 1 | Debug-trap pulse |

## Verification
The bench builds the unit with its defaults: 32-bit addresses, 16-bit ports and all four slots. This puts every kind and length field of the packed control word in play. Slot and access addresses are drawn from a 32-entry window, so random runs often produce partial overlaps, disabled-slot hits and several slots hitting in the same cycle. Directed cases cover the length-aligned boundary on each side, the 8-byte code and an 8-byte access that runs past the top of the 32-bit space. The no-wrap comparison is only tested by that last case.

// File: rtl/dbg_trap_pkg.sv
package dbg_trap_pkg;

  typedef enum logic [1:0] {
    KIND_EXEC = 2'd0,
    KIND_WR   = 2'd1,
    KIND_PIO  = 2'd2,
    KIND_RW   = 2'd3
  } bp_kind_e;

  typedef enum logic [1:0] {
    TGT_SLOT = 2'd0,
    TGT_STAT = 2'd1,
    TGT_CTRL = 2'd2,
    TGT_BAD  = 2'd3
  } reg_tgt_e;

  localparam int unsigned KIND_LSB     = 16;
  localparam int unsigned LEN_LSB      = 18;
  localparam int unsigned FIELD_STRIDE = 4;
  localparam int unsigned MAX_SLOTS    = 4;

  // length code to byte count; note the code order is not monotonic
  function automatic logic [3:0] len_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd1;
      2'd1:    return 4'd2;
      2'd2:    return 4'd8;
      default: return 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/dbg_slot_cmp.sv
module dbg_slot_cmp
  import dbg_trap_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PORT_W = 16
) (
  input  logic [ADDR_W-1:0] slot_addr_i,
  input  logic [1:0]        kind_i,
  input  logic [1:0]        len_i,
  input  logic              fetch_vld_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              mem_vld_i,
  input  logic              mem_wr_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic [1:0]        mem_size_i,
  input  logic              io_vld_i,
  input  logic [PORT_W-1:0] io_port_i,
  input  logic [1:0]        io_size_i,
  output logic              hit_o
);
  // one extra bit keeps range ends from wrapping at the top of the space
  localparam int unsigned XW = ADDR_W + 1;

  bp_kind_e          kind;
  logic [XW-1:0]     len_m1, sz_m1, slot_lo, slot_hi, acc_lo, acc_hi;
  logic [ADDR_W-1:0] aligned;
  logic              is_pio, overlap;

  always_comb begin
    kind    = bp_kind_e'(kind_i);
    is_pio  = (kind == KIND_PIO);
    len_m1  = XW'(len_bytes(len_i) - 4'd1);
    aligned = slot_addr_i & ~len_m1[ADDR_W-1:0];
    slot_lo = is_pio ? {1'b0, slot_addr_i} : {1'b0, aligned};
    slot_hi = slot_lo + len_m1;
    acc_lo  = is_pio ? XW'(io_port_i) : {1'b0, mem_addr_i};
    sz_m1   = is_pio ? XW'((4'd1 << io_size_i) - 4'd1)
                     : XW'((4'd1 << mem_size_i) - 4'd1);
    acc_hi  = acc_lo + sz_m1;
    overlap = (acc_hi >= slot_lo) && (acc_lo <= slot_hi);
    unique case (kind)
      KIND_EXEC: hit_o = fetch_vld_i && (fetch_addr_i == slot_addr_i);
      KIND_WR:   hit_o = mem_vld_i && mem_wr_i && overlap;
      KIND_RW:   hit_o = mem_vld_i && overlap;
      default:   hit_o = io_vld_i && overlap;
    endcase
  end

endmodule

// File: rtl/dbg_reg_decode.sv
module dbg_reg_decode
  import dbg_trap_pkg::*;
#(
  parameter int IDX_W     = 4,
  parameter int NUM_SLOTS = 4
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic             dext_i,
  output logic [1:0]       tgt_o,
  output logic [1:0]       slot_o
);
  reg_tgt_e tgt;

  always_comb begin
    tgt = TGT_BAD;
    if (!(|idx_i[IDX_W-1:3])) begin
      unique case (idx_i[2:0])
        3'd4:    tgt = dext_i ? TGT_BAD : TGT_STAT;
        3'd5:    tgt = dext_i ? TGT_BAD : TGT_CTRL;
        3'd6:    tgt = TGT_STAT;
        3'd7:    tgt = TGT_CTRL;
        default: tgt = (int'(idx_i[1:0]) < NUM_SLOTS) ? TGT_SLOT : TGT_BAD;
      endcase
    end
  end

  assign tgt_o  = tgt;
  assign slot_o = idx_i[1:0];

endmodule

// File: rtl/dbg_regbank.sv
module dbg_regbank
  import dbg_trap_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned STEP_BIT  = 14,
  parameter logic [31:0] STAT_ONES = 32'hFFFF_0FF0,
  parameter logic [31:0] CTRL_ONES = 32'h0000_0400
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [1:0]                        tgt_i,
  input  logic [1:0]                        slot_i,
  input  logic [ADDR_W-1:0]                 wdata_i,
  input  logic                              trap_i,
  input  logic [NUM_SLOTS-1:0]              hits_i,
  input  logic                              step_i,
  output logic [NUM_SLOTS-1:0][ADDR_W-1:0]  slot_addr_o,
  output logic [ADDR_W-1:0]                 ctrl_o,
  output logic [ADDR_W-1:0]                 stat_o
);
  localparam logic [ADDR_W-1:0] S_ONES = ADDR_W'(STAT_ONES);
  localparam logic [ADDR_W-1:0] C_ONES = ADDR_W'(CTRL_ONES);

  reg_tgt_e          tgt;
  logic [ADDR_W-1:0] ctrl_q, stat_q, stat_d;

  assign tgt = reg_tgt_e'(tgt_i);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_addr
    logic [ADDR_W-1:0] addr_q;
    always_ff @(posedge clk_i) begin
      if (!rst_ni)
        addr_q <= '0;
      else if (wr_en_i && tgt == TGT_SLOT && slot_i == 2'(g))
        addr_q <= wdata_i;
    end
    assign slot_addr_o[g] = addr_q;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)
      ctrl_q <= C_ONES;
    else if (wr_en_i && tgt == TGT_CTRL)
      ctrl_q <= wdata_i | C_ONES;
  end

  // a trap in the same cycle as a status write overrides the hit and step fields
  always_comb begin
    stat_d = stat_q;
    if (wr_en_i && tgt == TGT_STAT)
      stat_d = wdata_i | S_ONES;
    if (trap_i) begin
      stat_d[3:0] = 4'(hits_i);
      if (step_i)
        stat_d[STEP_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)
      stat_q <= S_ONES;
    else
      stat_q <= stat_d;
  end

  assign ctrl_o = ctrl_q;
  assign stat_o = stat_q;

endmodule

// File: rtl/dbg_trap_unit.sv
module dbg_trap_unit
  import dbg_trap_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PORT_W    = 16,
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned STEP_BIT  = 14,
  parameter logic [31:0] STAT_ONES = 32'hFFFF_0FF0,
  parameter logic [31:0] CTRL_ONES = 32'h0000_0400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dext_en_i,
  input  logic              fetch_vld_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              mem_vld_i,
  input  logic              mem_wr_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic [1:0]        mem_size_i,
  input  logic              io_vld_i,
  input  logic [PORT_W-1:0] io_port_i,
  input  logic [1:0]        io_size_i,
  input  logic              step_i,
  input  logic              reg_vld_i,
  input  logic              reg_wr_i,
  input  logic [3:0]        reg_idx_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  output logic [ADDR_W-1:0] reg_rdata_o,
  output logic              reg_rvld_o,
  output logic              reg_illegal_o,
  output logic              dbg_trap_o
);
  localparam int IDX_W = 4;

  logic [1:0]                       tgt_raw, slot_sel;
  reg_tgt_e                         tgt;
  logic                             legal, wr_en, trap_now;
  logic [NUM_SLOTS-1:0]             hits, slot_en;
  logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_addr_w;
  logic [ADDR_W-1:0]                ctrl_w, stat_w, rd_data;
  logic                             trap_q, rvld_q, bad_q;
  logic [ADDR_W-1:0]                rdata_q;

  dbg_reg_decode #(.IDX_W(IDX_W), .NUM_SLOTS(NUM_SLOTS)) u_dec (
    .idx_i (reg_idx_i),
    .dext_i(dext_en_i),
    .tgt_o (tgt_raw),
    .slot_o(slot_sel)
  );

  assign tgt   = reg_tgt_e'(tgt_raw);
  assign legal = (tgt != TGT_BAD);
  assign wr_en = reg_vld_i && reg_wr_i && legal;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam int unsigned KB = KIND_LSB + FIELD_STRIDE * g;
    localparam int unsigned LB = LEN_LSB + FIELD_STRIDE * g;
    assign slot_en[g] = ctrl_w[2*g] | ctrl_w[2*g+1];
    dbg_slot_cmp #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_cmp (
      .slot_addr_i (slot_addr_w[g]),
      .kind_i      (ctrl_w[KB +: 2]),
      .len_i       (ctrl_w[LB +: 2]),
      .fetch_vld_i (fetch_vld_i),
      .fetch_addr_i(fetch_addr_i),
      .mem_vld_i   (mem_vld_i),
      .mem_wr_i    (mem_wr_i),
      .mem_addr_i  (mem_addr_i),
      .mem_size_i  (mem_size_i),
      .io_vld_i    (io_vld_i),
      .io_port_i   (io_port_i),
      .io_size_i   (io_size_i),
      .hit_o       (hits[g])
    );
  end

  assign trap_now = (|(hits & slot_en)) || step_i;

  dbg_regbank #(
    .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .STEP_BIT(STEP_BIT),
    .STAT_ONES(STAT_ONES), .CTRL_ONES(CTRL_ONES)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .tgt_i      (tgt_raw),
    .slot_i     (slot_sel),
    .wdata_i    (reg_wdata_i),
    .trap_i     (trap_now),
    .hits_i     (hits),
    .step_i     (step_i),
    .slot_addr_o(slot_addr_w),
    .ctrl_o     (ctrl_w),
    .stat_o     (stat_w)
  );

  always_comb begin
    unique case (tgt)
      TGT_SLOT: rd_data = slot_addr_w[slot_sel];
      TGT_STAT: rd_data = stat_w;
      TGT_CTRL: rd_data = ctrl_w;
      default:  rd_data = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      trap_q  <= 1'b0;
      rvld_q  <= 1'b0;
      bad_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      trap_q <= trap_now;
      rvld_q <= reg_vld_i && !reg_wr_i && legal;
      bad_q  <= reg_vld_i && !legal;
      if (reg_vld_i && !reg_wr_i && legal)
        rdata_q <= rd_data;
    end
  end

  assign dbg_trap_o    = trap_q;
  assign reg_rvld_o    = rvld_q;
  assign reg_illegal_o = bad_q;
  assign reg_rdata_o   = rdata_q;

endmodule

// File: rtl/dbg_trap_chk.sv
module dbg_trap_chk #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned STEP_BIT  = 14,
  parameter logic [31:0] CTRL_ONES = 32'h0000_0400
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dext_en_i,
  input logic              fetch_vld_i,
  input logic              mem_vld_i,
  input logic              io_vld_i,
  input logic              step_i,
  input logic              reg_vld_i,
  input logic              reg_wr_i,
  input logic [3:0]        reg_idx_i,
  input logic              reg_rvld_o,
  input logic              reg_illegal_o,
  input logic              dbg_trap_o,
  input logic [ADDR_W-1:0] ctrl_i,
  input logic [ADDR_W-1:0] stat_i
);
  localparam logic [ADDR_W-1:0] C_ONES = ADDR_W'(CTRL_ONES);

  AST_STEP_TRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> dbg_trap_o); // R7
  AST_STEP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> stat_i[STEP_BIT]); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fetch_vld_i || mem_vld_i || io_vld_i || step_i) |=> !dbg_trap_o); // R6
  AST_NO_ENABLE_NO_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[2*NUM_SLOTS-1:0] == '0 && !step_i) |=> !dbg_trap_o); // R6
  AST_STAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(fetch_vld_i || mem_vld_i || io_vld_i || step_i) && !(reg_vld_i && reg_wr_i))
      |=> $stable(stat_i)); // R6
  AST_HIGH_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_vld_i && reg_idx_i[3]) |=> (reg_illegal_o && !reg_rvld_o)); // R10
  AST_ALIAS_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_vld_i && dext_en_i && reg_idx_i[3:1] == 3'b010) |=> reg_illegal_o); // R11
  AST_CTRL_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i & C_ONES) == C_ONES); // R9

endmodule

bind dbg_trap_unit dbg_trap_chk #(
  .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .STEP_BIT(STEP_BIT), .CTRL_ONES(CTRL_ONES)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dext_en_i    (dext_en_i),
  .fetch_vld_i  (fetch_vld_i),
  .mem_vld_i    (mem_vld_i),
  .io_vld_i     (io_vld_i),
  .step_i       (step_i),
  .reg_vld_i    (reg_vld_i),
  .reg_wr_i     (reg_wr_i),
  .reg_idx_i    (reg_idx_i),
  .reg_rvld_o   (reg_rvld_o),
  .reg_illegal_o(reg_illegal_o),
  .dbg_trap_o   (dbg_trap_o),
  .ctrl_i       (ctrl_w),
  .stat_i       (stat_w)
);

// File: tb/dbg_trap_unit_tb_top.sv
`timescale 1ns/1ps
module dbg_trap_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dext = 1'b0;
  logic        fv = 1'b0, mv = 1'b0, mw = 1'b0, iv = 1'b0, st = 1'b0;
  logic [31:0] fa = '0, ma = '0;
  logic [1:0]  ms = '0, is = '0;
  logic [15:0] ip = '0;
  logic        rv = 1'b0, rw = 1'b0;
  logic [3:0]  ridx = '0;
  logic [31:0] rwd = '0;
  logic [31:0] rdata;
  logic        rvld, rbad, trap;

  always #4 clk = ~clk;

  dbg_trap_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dext_en_i(dext),
    .fetch_vld_i(fv), .fetch_addr_i(fa),
    .mem_vld_i(mv), .mem_wr_i(mw), .mem_addr_i(ma), .mem_size_i(ms),
    .io_vld_i(iv), .io_port_i(ip), .io_size_i(is),
    .step_i(st),
    .reg_vld_i(rv), .reg_wr_i(rw), .reg_idx_i(ridx), .reg_wdata_i(rwd),
    .reg_rdata_o(rdata), .reg_rvld_o(rvld), .reg_illegal_o(rbad),
    .dbg_trap_o(trap)
  );

  int n_chk = 0;
  int n_fail = 0;

  // reference state
  logic [31:0] m_slot [4];
  logic [31:0] m_ctrl, m_stat;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic longint len_of(input logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 8;
      default: return 4;
    endcase
  endfunction

  function automatic bit ov(input longint lo, input longint ln, input longint a, input longint n);
    return (a + n - 1 >= lo) && (a <= lo + ln - 1);
  endfunction

  function automatic bit m_hit(input int i);
    logic [1:0] k;
    longint ln, s, base;
    k    = m_ctrl[16+4*i +: 2];
    ln   = len_of(m_ctrl[18+4*i +: 2]);
    s    = longint'({32'b0, m_slot[i]});
    base = s - (s % ln);
    case (k)
      2'd0: return fv && (fa == m_slot[i]);
      2'd1: return mv && mw && ov(base, ln, longint'({32'b0, ma}), longint'(1) << ms);
      2'd3: return mv && ov(base, ln, longint'({32'b0, ma}), longint'(1) << ms);
      default: return iv && ov(s, ln, longint'({48'b0, ip}), longint'(1) << is);
    endcase
  endfunction

  // 0 slot, 1 status, 2 control, 3 illegal
  function automatic int m_tgt(input logic [3:0] idx);
    if (idx >= 8) return 3;
    if (idx < 4) return 0;
    if (idx == 4) return dext ? 3 : 1;
    if (idx == 5) return dext ? 3 : 2;
    if (idx == 6) return 1;
    return 2;
  endfunction

  // called at a negedge with the event inputs already driven
  task automatic ev(input int exp_trap, input string tag);
    logic [3:0] h, en;
    bit mt;
    for (int i = 0; i < 4; i++) begin
      h[i]  = m_hit(i);
      en[i] = m_ctrl[2*i] | m_ctrl[2*i+1];
    end
    mt = (|(h & en)) || st;
    @(negedge clk);
    chk(trap == ((exp_trap >= 0) ? exp_trap[0] : mt), tag, 64'(trap), 64'((exp_trap >= 0) ? exp_trap[0] : mt));
    if (mt) begin
      m_stat[3:0] = h;
      if (st) m_stat[14] = 1'b1;
    end
    fv = 0; mv = 0; mw = 0; iv = 0; st = 0;
  endtask

  task automatic fetch(input logic [31:0] a, input int e, input string tag);
    fv = 1; fa = a;
    ev(e, tag);
  endtask

  task automatic mem(input bit w, input logic [31:0] a, input logic [1:0] s, input int e, input string tag);
    mv = 1; mw = w; ma = a; ms = s;
    ev(e, tag);
  endtask

  task automatic pio(input logic [15:0] p, input logic [1:0] s, input int e, input string tag);
    iv = 1; ip = p; is = s;
    ev(e, tag);
  endtask

  task automatic rd(input logic [3:0] idx, input string tag);
    int t;
    logic [31:0] exp;
    t = m_tgt(idx);
    exp = (t == 0) ? m_slot[idx[1:0]] : (t == 1) ? m_stat : m_ctrl;
    rv = 1; rw = 0; ridx = idx;
    @(negedge clk);
    rv = 0;
    if (t == 3)
      chk(rbad && !rvld, tag, {62'b0, rbad, rvld}, 64'h2);
    else
      chk(rvld && !rbad && rdata == exp, tag, {rvld, rbad, 30'b0, rdata}, {2'b10, 30'b0, exp});
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d, input string tag);
    int t;
    t = m_tgt(idx);
    rv = 1; rw = 1; ridx = idx; rwd = d;
    @(negedge clk);
    rv = 0; rw = 0;
    chk(rbad == (t == 3), tag, 64'(rbad), 64'(t == 3));
    case (t)
      0: m_slot[idx[1:0]] = d;
      1: m_stat = d | 32'hFFFF_0FF0;
      2: m_ctrl = d | 32'h0000_0400;
      default: ;
    endcase
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired (all requirements)");
    finish_run();
  end

  initial begin
    logic [31:0] c;
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) m_slot[i] = '0;
    m_ctrl = 32'h0000_0400;
    m_stat = 32'hFFFF_0FF0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R9 reset state
    chk(!trap && !rvld && !rbad, "R9 reset outputs", {61'b0, trap, rvld, rbad}, 64'h0);
    rd(4'd6, "R9 status reset");
    rd(4'd7, "R9 control reset");
    rd(4'd0, "R8 slot reset");
    wr(4'd6, 32'h0, "R9");
    rd(4'd6, "R9 status ones kept");
    wr(4'd7, 32'h0, "R9");
    rd(4'd7, "R9 control ones kept");

    // R10 out-of-map indices
    rd(4'd9, "R10 read");
    wr(4'd12, 32'hFFFF_FFFF, "R10 write");
    rd(4'd7, "R10 no side effect");
    rd(4'd3, "R8 slot read");

    // R11 aliasing
    rd(4'd4, "R11 alias status");
    rd(4'd5, "R11 alias control");
    dext = 1;
    rd(4'd4, "R11 blocked");
    wr(4'd5, 32'hFFFF_FFFF, "R11 blocked write");
    rd(4'd7, "R11 no side effect");
    dext = 0;

    // R3 execute, slot 0 local enable
    wr(4'd0, 32'h2000, "R8");
    c = 32'h0000_0001;
    wr(4'd7, c, "R1");
    fetch(32'h2000, 1, "R3 exact");
    rd(4'd6, "R6 status hit");
    fetch(32'h2001, 0, "R3 off by one");

    // R4 write-only, length 4, slot 1 global enable
    wr(4'd1, 32'h3006, "R8");
    c |= (32'h1 << 3) | (32'h1 << 20) | (32'h3 << 22);
    wr(4'd7, c, "R1");
    mem(1, 32'h3004, 2'd0, 1, "R4 aligned base");
    mem(0, 32'h3007, 2'd0, 0, "R4 read ignored");
    mem(1, 32'h3003, 2'd0, 0, "R4 below base");
    mem(1, 32'h3002, 2'd2, 1, "R4 partial overlap");
    rd(4'd6, "R4 status");

    // R2 eight-byte code on read-or-write slot 2
    wr(4'd2, 32'h4003, "R8");
    c |= (32'h1 << 4) | (32'h3 << 24) | (32'h2 << 26);
    wr(4'd7, c, "R1");
    mem(0, 32'h4007, 2'd0, 1, "R2 last byte");
    mem(0, 32'h4008, 2'd0, 0, "R2 past end");
    mem(0, 32'h3FFF, 2'd1, 1, "R2 straddle low");

    // R5 port I/O on slot 3, length 2
    wr(4'd3, 32'h60, "R8");
    c |= (32'h1 << 7) | (32'h2 << 28) | (32'h1 << 30);
    wr(4'd7, c, "R1");
    pio(16'h5F, 2'd1, 1, "R5 overlap low");
    pio(16'h62, 2'd0, 0, "R5 above");
    pio(16'h5E, 2'd0, 0, "R5 below");
    pio(16'h61, 2'd2, 1, "R5 overlap high");

    // R6 disabled slot 2 hits without trapping, then is recorded with slot 0
    c &= ~(32'h1 << 4);
    wr(4'd7, c, "R1");
    rd(4'd6, "R6 before");
    mem(0, 32'h4001, 2'd0, 0, "R6 disabled only");
    rd(4'd6, "R6 status unchanged");
    fv = 1; fa = 32'h2000; mv = 1; mw = 1; ma = 32'h4000; ms = 2'd0;
    ev(1, "R6 mixed hit");
    rd(4'd6, "R6 disabled bit recorded");

    // R7 single step
    st = 1;
    ev(1, "R7 step trap");
    rd(4'd6, "R7 step flag");
    fetch(32'h2000, 1, "R7 flag kept");
    rd(4'd6, "R7 flag sticky");

    // R4 top of address space
    wr(4'd1, 32'hFFFF_FFFE, "R8");
    mem(1, 32'hFFFF_FFFF, 2'd3, 1, "R4 no wrap");
    rd(4'd6, "R4 status top");

    // constrained random
    for (int n = 0; n < 600; n++) begin
      int sel;
      sel = $urandom_range(0, 15);
      if (sel == 0) begin
        wr(4'd7, $urandom(), "R1 random control");
      end else if (sel == 1) begin
        wr(4'($urandom_range(0, 3)), 32'h1000 + $urandom_range(0, 31), "R8 random slot");
      end else if (sel == 2) begin
        dext = 1'($urandom_range(0, 1));
        rd(4'($urandom_range(0, 15)), "R8 random read");
      end else begin
        fv = 1'($urandom_range(0, 1));
        fa = 32'h1000 + $urandom_range(0, 31);
        mv = 1'($urandom_range(0, 1));
        mw = 1'($urandom_range(0, 1));
        ma = 32'h1000 + $urandom_range(0, 31);
        ms = 2'($urandom_range(0, 3));
        iv = 1'($urandom_range(0, 1));
        ip = 16'h1000 + 16'($urandom_range(0, 31));
        is = 2'($urandom_range(0, 2));
        st = ($urandom_range(0, 15) == 0);
        ev(-1, "R6 random trap");
        dext = 0;
        rd(4'd6, "R6 random status");
      end
    end

    finish_run();
  end

endmodule